// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a downstream port that supports hot-plug, and decides when to raise a hot-plug interrupt. Configuration software writes and reads the two 16-bit registers through a small register port with byte enables. The port logic feeds in three kinds of stimulus: attention-button presses, device insertion requests and device removal requests. Each insertion or removal request is answered with an accept or reject result.

Software acknowledges an event by writing 1 to its status bit. Every write to slot control counts as one command. The command completes at once, and its completion is itself an event. The interrupt side works on a single notification condition. In level mode that condition drives a level interrupt line. In message mode a false-to-true change of the condition produces a one-cycle request to the message interrupt logic. The indicator fields are plain register state.

Top module: `hps_slot_ctrl`

## Requirements
- R1: Slot control layout: bit 0 button-event enable, bit 3 presence-change enable, bit 4 command-done enable, bit 5 hot-plug interrupt enable, bits 7:6 attention indicator, bits 9:8 power indicator, bit 11 interlock trigger. Slot status layout: bit 0 button pressed, bit 3 presence changed, bit 4 command done, bit 6 device present, bit 7 interlock engaged. All other bits read 0, and writes to them are ignored.
- R2: While `rst` is high, all control fields are cleared except the two indicator fields, which take the off code 2'b11. Control therefore reads 16'h03C0. The button, presence-changed, command-done and interlock status bits clear, and `intx_out` and `msg_req` go low.
- R3: Each of the three event bits is set by its event and cleared by writing 1 to it in slot status. If the event and the clear fall in the same cycle, the bit stays set.
- R4: A write with `cfg_sel`=0 and at least one byte enable set is one command. It sets the command-done status bit at the same clock edge that applies the write.
- R5: Writing 1 to control bit 11 (with byte 1 enabled) toggles the interlock status bit. Control bit 11 always reads 0.
- R6: An insertion or removal request is answered one cycle later with `resp_valid`=1. `resp_accept`=0 when the interlock status bit is set, and the request then changes nothing. An accepted insertion sets device present and presence changed. An accepted removal clears device present and sets presence changed. If both requests arrive in the same cycle, they are treated as an insertion.
- R7: During reset, device present takes the value of `boot_present`, and no presence-changed event is raised.
- R8: The notification condition is true when the interrupt enable is set and at least one event bit is set together with its enable. In level mode (`msi_mode`=0), `intx_out` equals the condition one clock after the register change. In message mode, `intx_out` stays 0.
- R9: In message mode, `msg_req` is high for exactly one cycle, one clock after the condition goes from false to true. Setting an event bit that is already set, or the condition falling, issues no request.
- R10: A status write that clears the last enabled pending event drops `intx_out` one clock later.
- R11: Byte enables select which bytes are written. A write with no byte enable changes neither register, and for a status write with no byte enable nothing is cleared.
- R12: `cfg_rdata` returns slot status when `cfg_sel`=1 and slot control when `cfg_sel`=0, registered one clock after `cfg_sel` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_present | input | 1 | Device present at power-up, loaded during reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 status |
| cfg_be | input | 2 | Byte enables |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Registered read data |
| evt_button | input | 1 | Attention button pressed, one-cycle pulse |
| req_insert | input | 1 | Device insertion request |
| req_remove | input | 1 | Device removal request |
| resp_valid | output | 1 | Result of a request is valid |
| resp_accept | output | 1 | Request accepted (1) or rejected (0) |
| msi_mode | input | 1 | 1 selects message interrupts, 0 selects level interrupt |
| intx_out | output | 1 | Level interrupt line |
| msg_req | output | 1 | One-cycle request to message interrupt logic |

## Verification
The bench aims at the cases where an event and its clear collide in one cycle. A design that let the clear win would lose a button press. A repeated event while the condition is already true must stay silent in message mode; a design that pulsed on every event would flood the message logic. Interlock handling is checked through both toggles and a removal attempted while locked: a wrong design would store the trigger bit or drop the device while locked. Reset is also checked after the registers have been disturbed, which catches indicators left at 00 instead of off.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int SLOT_REG_W = 16;

  // control bit positions
  localparam int C_BTN_EN  = 0;
  localparam int C_PDC_EN  = 3;
  localparam int C_CMD_EN  = 4;
  localparam int C_HP_IE   = 5;
  localparam int C_AIND_LO = 6;
  localparam int C_PIND_LO = 8;
  localparam int C_ILK_TRG = 11;

  // status bit positions (event bits line up with their enables)
  localparam int S_BTN = 0;
  localparam int S_PDC = 3;
  localparam int S_CMD = 4;
  localparam int S_PDS = 6;
  localparam int S_ILK = 7;

  localparam logic [1:0] IND_OFF = 2'b11;

  localparam logic [SLOT_REG_W-1:0] CTL_WMASK =
    (SLOT_REG_W'(1) << C_BTN_EN) | (SLOT_REG_W'(1) << C_PDC_EN) |
    (SLOT_REG_W'(1) << C_CMD_EN) | (SLOT_REG_W'(1) << C_HP_IE) |
    (SLOT_REG_W'(3) << C_AIND_LO) | (SLOT_REG_W'(3) << C_PIND_LO);

  localparam logic [SLOT_REG_W-1:0] CTL_RST =
    (SLOT_REG_W'(IND_OFF) << C_AIND_LO) | (SLOT_REG_W'(IND_OFF) << C_PIND_LO);

  localparam logic [SLOT_REG_W-1:0] EVT_MASK =
    (SLOT_REG_W'(1) << S_BTN) | (SLOT_REG_W'(1) << S_PDC) |
    (SLOT_REG_W'(1) << S_CMD);
endpackage

// File: rtl/hps_ctl_reg.sv
module hps_ctl_reg
  import hps_pkg::*;
#(
  parameter int REG_W = SLOT_REG_W,
  localparam int BE_W = REG_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  be,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctl_q,
  output logic             cmd_pulse,
  output logic             ilk_toggle
);
  logic [REG_W-1:0] bmask;
  logic [REG_W-1:0] wmask;

  for (genvar b = 0; b < BE_W; b++) begin : g_bmask
    assign bmask[b*8 +: 8] = {8{be[b]}};
  end

  assign wmask      = bmask & REG_W'(CTL_WMASK);
  assign cmd_pulse  = wr_en && (|be);
  assign ilk_toggle = wr_en && bmask[C_ILK_TRG] && wdata[C_ILK_TRG];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= REG_W'(CTL_RST);
    end else if (wr_en) begin
      ctl_q <= (ctl_q & ~wmask) | (wdata & wmask);
    end
  end

  // R2: indicators come out of reset at the off code
  p_ind_off_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctl_q[C_PIND_LO +: 2] == IND_OFF && ctl_q[C_AIND_LO +: 2] == IND_OFF));

  // R11: no write, no change
  p_ctl_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !$past(rst)) |=> $stable(ctl_q));
endmodule

// File: rtl/hps_sts_reg.sv
module hps_sts_reg
  import hps_pkg::*;
#(
  parameter int REG_W = SLOT_REG_W,
  localparam int BE_W = REG_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_present,
  input  logic             w1c_en,
  input  logic [BE_W-1:0]  be,
  input  logic [REG_W-1:0] wdata,
  input  logic             ev_button,
  input  logic             ev_cmd,
  input  logic             ilk_toggle,
  input  logic             req_insert,
  input  logic             req_remove,
  output logic [REG_W-1:0] sts_q,
  output logic             resp_valid,
  output logic             resp_accept
);
  logic [REG_W-1:0] bmask;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] evt_q;
  logic             pds_q;
  logic             ilk_q;
  logic             any_req;
  logic             accepted;

  for (genvar b = 0; b < BE_W; b++) begin : g_bmask
    assign bmask[b*8 +: 8] = {8{be[b]}};
  end

  assign any_req  = req_insert || req_remove;
  assign accepted = any_req && !ilk_q;
  assign clr_vec  = {REG_W{w1c_en}} & bmask & wdata & REG_W'(EVT_MASK);

  always_comb begin
    set_vec        = '0;
    set_vec[S_BTN] = ev_button;
    set_vec[S_PDC] = accepted;
    set_vec[S_CMD] = ev_cmd;
  end

  // event set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
    end else begin
      evt_q <= ((evt_q & ~clr_vec) | set_vec) & REG_W'(EVT_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pds_q       <= boot_present;
      ilk_q       <= 1'b0;
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
    end else begin
      if (accepted) pds_q <= req_insert;
      if (ilk_toggle) ilk_q <= !ilk_q;
      resp_valid  <= any_req;
      resp_accept <= accepted;
    end
  end

  always_comb begin
    sts_q        = evt_q;
    sts_q[S_PDS] = pds_q;
    sts_q[S_ILK] = ilk_q;
  end

  // R3: an event always leaves its bit set
  p_btn_set_r3: assert property (@(posedge clk) disable iff (rst)
    ev_button |=> sts_q[S_BTN]);

  // R5: trigger toggles the interlock status
  p_ilk_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    ilk_toggle |=> (ilk_q != $past(ilk_q)));

  // R6: locked slot rejects and keeps presence
  p_reject_locked_r6: assert property (@(posedge clk) disable iff (rst)
    (any_req && ilk_q) |=> (resp_valid && !resp_accept && $stable(pds_q)));

  // R6: accepted insertion marks device present and changed
  p_insert_ok_r6: assert property (@(posedge clk) disable iff (rst)
    (req_insert && !ilk_q) |=> (pds_q && sts_q[S_PDC] && resp_accept));
endmodule

// File: rtl/hps_notify.sv
module hps_notify
  import hps_pkg::*;
#(
  parameter int REG_W = SLOT_REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ctl_q,
  input  logic [REG_W-1:0] sts_q,
  input  logic             msi_mode,
  output logic             intx_out,
  output logic             msg_req
);
  logic cond;
  logic cond_q;

  assign cond = ctl_q[C_HP_IE] && (|(ctl_q & sts_q & REG_W'(EVT_MASK)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q   <= 1'b0;
      intx_out <= 1'b0;
      msg_req  <= 1'b0;
    end else begin
      cond_q   <= cond;
      intx_out <= cond && !msi_mode;
      msg_req  <= cond && !cond_q && msi_mode;
    end
  end

  // R9: request lasts one cycle
  p_msg_single_r9: assert property (@(posedge clk) disable iff (rst)
    msg_req |=> !msg_req);

  // R9: requests only in message mode
  p_msg_mode_r9: assert property (@(posedge clk) disable iff (rst)
    msg_req |-> $past(msi_mode));

  // R8: level line needs the interrupt enable and level mode
  p_intx_gate_r8: assert property (@(posedge clk) disable iff (rst)
    intx_out |-> ($past(ctl_q[C_HP_IE]) && !$past(msi_mode)));
endmodule

// File: rtl/hps_slot_ctrl.sv
module hps_slot_ctrl
  import hps_pkg::*;
#(
  parameter int REG_W = SLOT_REG_W,
  localparam int BE_W = REG_W / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_present,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [BE_W-1:0]  cfg_be,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             evt_button,
  input  logic             req_insert,
  input  logic             req_remove,
  output logic             resp_valid,
  output logic             resp_accept,
  input  logic             msi_mode,
  output logic             intx_out,
  output logic             msg_req
);
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] sts_q;
  logic             cmd_pulse;
  logic             ilk_toggle;
  logic             ctl_wr;
  logic             sts_wr;

  assign ctl_wr = cfg_wr && !cfg_sel;
  assign sts_wr = cfg_wr && cfg_sel;

  hps_ctl_reg #(.REG_W(REG_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ctl_wr),
    .be         (cfg_be),
    .wdata      (cfg_wdata),
    .ctl_q      (ctl_q),
    .cmd_pulse  (cmd_pulse),
    .ilk_toggle (ilk_toggle)
  );

  hps_sts_reg #(.REG_W(REG_W)) u_sts (
    .clk          (clk),
    .rst          (rst),
    .boot_present (boot_present),
    .w1c_en       (sts_wr),
    .be           (cfg_be),
    .wdata        (cfg_wdata),
    .ev_button    (evt_button),
    .ev_cmd       (cmd_pulse),
    .ilk_toggle   (ilk_toggle),
    .req_insert   (req_insert),
    .req_remove   (req_remove),
    .sts_q        (sts_q),
    .resp_valid   (resp_valid),
    .resp_accept  (resp_accept)
  );

  hps_notify #(.REG_W(REG_W)) u_ntf (
    .clk      (clk),
    .rst      (rst),
    .ctl_q    (ctl_q),
    .sts_q    (sts_q),
    .msi_mode (msi_mode),
    .intx_out (intx_out),
    .msg_req  (msg_req)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= cfg_sel ? sts_q : ctl_q;
  end

  // R4: a control write completes as a command at once
  p_cmd_done_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && (|cfg_be)) |=> sts_q[S_CMD]);

  // R5: interlock trigger never reads back
  p_trg_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[C_ILK_TRG]);
endmodule

// File: tb/tb_hps_slot_ctrl.sv
module tb_hps_slot_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_present = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [1:0]  cfg_be = 2'b00;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] cfg_rdata;
  logic        evt_button = 1'b0;
  logic        req_insert = 1'b0;
  logic        req_remove = 1'b0;
  logic        resp_valid;
  logic        resp_accept;
  logic        msi_mode = 1'b0;
  logic        intx_out;
  logic        msg_req;

  int total = 0;
  int bad = 0;
  int msg_cnt = 0;

  hps_slot_ctrl dut (
    .clk(clk), .rst(rst), .boot_present(boot_present),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .evt_button(evt_button), .req_insert(req_insert), .req_remove(req_remove),
    .resp_valid(resp_valid), .resp_accept(resp_accept),
    .msi_mode(msi_mode), .intx_out(intx_out), .msg_req(msg_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (!rst && msg_req) msg_cnt++;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic present);
    boot_present = present;
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0; cfg_be = 2'b00;
  endtask

  task automatic rd(input logic sel, output logic [15:0] d);
    cfg_sel = sel;
    tick();
    d = cfg_rdata;
  endtask

  task automatic pulse_button();
    evt_button = 1'b1; tick(); evt_button = 1'b0;
  endtask

  task automatic request(input logic ins, input logic rem);
    req_insert = ins; req_remove = rem;
    tick();
    req_insert = 1'b0; req_remove = 1'b0;
  endtask

  task automatic t_reset_values();
    logic [15:0] d;
    do_reset(1'b1);
    rd(1'b0, d); check("R2 ctl after reset", d, 16'h03C0);
    rd(1'b1, d); check("R7 status with boot device", d, 16'h0040);
    check("R2 intx after reset", intx_out, 0);
  endtask

  task automatic t_byte_enables();
    logic [15:0] d;
    do_reset(1'b1);
    wr(1'b0, 2'b10, 16'hF6FF);
    rd(1'b0, d); check("R11 high byte only", d, 16'h02C0);
    wr(1'b0, 2'b01, 16'hFFFF);
    rd(1'b0, d); check("R1 writable low byte", d, 16'h02F9);
    wr(1'b0, 2'b00, 16'h0000);
    rd(1'b0, d); check("R11 no byte enable", d, 16'h02F9);
    rd(1'b1, d); check("R12 status read select", d, 16'h0050);
  endtask

  task automatic t_cmd_intx();
    logic [15:0] d;
    do_reset(1'b1);
    msi_mode = 1'b0;
    wr(1'b0, 2'b01, 16'h0030);
    check("R8 intx one clock later", intx_out, 0);
    tick();
    check("R4 command done raises intx", intx_out, 1);
    wr(1'b1, 2'b01, 16'h0010);
    tick();
    check("R10 intx drops after clear", intx_out, 0);
    rd(1'b1, d); check("R3 command bit cleared", d, 16'h0040);
  endtask

  task automatic t_event_clear();
    logic [15:0] d;
    do_reset(1'b1);
    pulse_button();
    rd(1'b1, d); check("R3 button sets bit", d, 16'h0041);
    evt_button = 1'b1;
    wr(1'b1, 2'b01, 16'h0001);
    evt_button = 1'b0;
    rd(1'b1, d); check("R3 set wins over clear", d, 16'h0041);
    wr(1'b1, 2'b00, 16'h0001);
    rd(1'b1, d); check("R11 clear without byte enable", d, 16'h0041);
    wr(1'b1, 2'b01, 16'h00FF);
    rd(1'b1, d); check("R3 write one clears", d, 16'h0040);
  endtask

  task automatic t_message();
    int m0;
    do_reset(1'b1);
    msi_mode = 1'b1;
    wr(1'b0, 2'b01, 16'h0021);
    tick(); tick();
    m0 = msg_cnt;
    check("R9 no request while disabled event", m0, 0);
    pulse_button();
    tick(); tick(); tick();
    check("R9 one request on rise", msg_cnt, 1);
    check("R8 intx low in message mode", intx_out, 0);
    pulse_button();
    tick(); tick(); tick();
    check("R9 repeat event silent", msg_cnt, 1);
    wr(1'b1, 2'b01, 16'h0011);
    tick(); tick(); tick();
    check("R9 falling condition silent", msg_cnt, 1);
    pulse_button();
    tick(); tick(); tick();
    check("R9 new request after clear", msg_cnt, 2);
    msi_mode = 1'b0;
  endtask

  task automatic t_interlock();
    logic [15:0] d;
    do_reset(1'b1);
    wr(1'b0, 2'b10, 16'h0800);
    rd(1'b0, d); check("R5 trigger reads zero", d, 16'h00C0);
    rd(1'b1, d); check("R5 interlock engaged", d, 16'h00D0);
    request(1'b0, 1'b1);
    check("R6 locked valid", resp_valid, 1);
    check("R6 locked reject", resp_accept, 0);
    rd(1'b1, d); check("R6 locked no change", d, 16'h00D0);
    wr(1'b0, 2'b10, 16'h0800);
    rd(1'b1, d); check("R5 interlock released", d, 16'h0050);
    request(1'b0, 1'b1);
    check("R6 removal accepted", resp_accept, 1);
    rd(1'b1, d); check("R6 removal status", d, 16'h0018);
  endtask

  task automatic t_insert_and_reset();
    logic [15:0] d;
    do_reset(1'b0);
    rd(1'b1, d); check("R7 empty slot no event", d, 16'h0000);
    request(1'b1, 1'b0);
    check("R6 insert valid", resp_valid, 1);
    check("R6 insert accepted", resp_accept, 1);
    rd(1'b1, d); check("R6 insert status", d, 16'h0048);
    wr(1'b0, 2'b11, 16'h0339);
    tick();
    check("R8 intx with enabled events", intx_out, 1);
    do_reset(1'b1);
    rd(1'b0, d); check("R2 ctl restored", d, 16'h03C0);
    rd(1'b1, d); check("R2 status cleared", d, 16'h0040);
    check("R2 intx cleared", intx_out, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_values();
    t_byte_enables();
    t_cmd_intx();
    t_event_clear();
    t_message();
    t_interlock();
    t_insert_and_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule